// File: doc/BRIEF.md
# Serial channel-associated signaling inserter

The block sits on the transmit side of a 2.048 Mbit/s E1 line path. It takes channel-associated signaling from a one-bit serial input, clocked by the transmit system clock, and merges it into the outgoing serial data stream in frame alignment. The serial input uses the same timing as the data. A frame sync pulse marks bit 1 of timeslot 0. An optional multiframe sync pulse marks frame 0 of the 16-frame multiframe.

From an ordinary timeslot only the signaling nibble is taken: bits 5 to 8 (bit 1 goes out first). Bits 1 to 4 are dropped. Timeslots 0 and 16 are taken as full octets. Captured values collect in a capture buffer. The whole buffer moves to an insertion buffer at the last bit of a capture frame. From there it is spread over timeslot 16 of the following frames, following the usual multiframe layout. When multiframe mode is on, only the last frame of each multiframe is sampled, so the signaling multiframe stays locked to the CRC-4 multiframe. A bit-wide override from the internal signaling controller wins over everything else.

Top module: `cas_inserter`

## Requirements
- R1: While rst_ni is low, data_o is 0, and both buffers are cleared to all zeros.
- R2: The bit where sync_i or mfsync_i is high is bit 1 of timeslot 0. mfsync_i also sets the frame number to 0. A sync_i on its own advances the frame number modulo 16. Without a pulse, the bit and slot counters run on at 8 bits per slot and 32 slots per frame.
- R3: In timeslots other than 0 and 16, data_o equals data_i of the previous clock, unless the override is active. All of R3 to R11 have this one-clock latency.
- R4: In an ordinary timeslot, only the sig_i bits at bit positions 5 to 8 are captured, into that timeslot's nibble. Bits 1 to 4 of sig_i have no effect.
- R5: In timeslots 0 and 16, all 8 bits of sig_i are captured.
- R6: In timeslot 16 of frame n (1 to 15), bits 1 to 4 carry the nibble of timeslot n and bits 5 to 8 carry the nibble of timeslot n+16. Each nibble goes out in captured order.
- R7: In timeslot 16 of frame 0, the captured timeslot-16 octet is sent unchanged.
- R8: In timeslot 0 of odd frames, the captured timeslot-0 octet is sent. In timeslot 0 of even frames, data_i passes through.
- R9: With mf_mode_i high, capture happens only in frame 15. sig_i in frames 0 to 14 has no effect. The capture is moved to the insertion buffer at the last bit of frame 15, so it goes out during the whole next multiframe.
- R10: With mf_mode_i low, capture runs in every frame and the transfer happens at the last bit of every frame. Signaling taken in frame f goes out from frame f+1.
- R11: While int_en_i is high, data_o on the next clock equals int_bit_i, in any position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit system clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame pulse: this bit is bit 1 of timeslot 0 |
| mfsync_i | input | 1 | Multiframe pulse: this bit starts frame 0 |
| mf_mode_i | input | 1 | 1: capture only in frame 15 (CRC-4 multiframe mode) |
| sig_i | input | 1 | Serial external signaling |
| data_i | input | 1 | Serial transmit data |
| int_en_i | input | 1 | Internal signaling controller drives this bit |
| int_bit_i | input | 1 | Bit from the internal signaling controller |
| data_o | output | 1 | Serial transmit data with signaling inserted |

## Verification
Random data_i and sig_i run through several multiframes in both capture modes. Because sig_i changes in every frame, including bits 1 to 4 and the frames that multiframe mode must skip, any leak of a dropped bit or a wrong capture frame shows up as a wrong nibble in a later timeslot 16. Sparse random override pulses land in data, timeslot 0 and timeslot 16 positions. These show that the override wins wherever it falls. A multiframe pulse cut into the middle of a frame tests that both the bit position and the frame number restart.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int SLOTS    = 32;
  localparam int BITS     = 8;
  localparam int FRAMES   = 16;
  localparam int NIB      = 4;
  localparam int SIG_SLOT = 16;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int BIT_W    = $clog2(BITS);
  localparam int FRAME_W  = $clog2(FRAMES);
  localparam int NIB_W    = $clog2(NIB);
endpackage

// File: rtl/cas_timing.sv
module cas_timing
  import cas_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic               mfsync_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [BIT_W-1:0]   bit_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [BIT_W-1:0]   bit_q;
  logic               start;

  assign start = sync_i | mfsync_i;

  always_comb begin
    bit_o  = start ? '0 : bit_q;
    slot_o = start ? '0 : slot_q;
    if (mfsync_i)    frame_o = '0;
    else if (sync_i) frame_o = (frame_q == FRAME_W'(FRAMES-1)) ? '0 : frame_q + 1'b1;
    else             frame_o = frame_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      frame_q <= frame_o;
      if (bit_o == BIT_W'(BITS-1)) begin
        bit_q  <= '0;
        slot_q <= (slot_o == SLOT_W'(SLOTS-1)) ? '0 : slot_o + 1'b1;
      end else begin
        bit_q  <= bit_o + 1'b1;
        slot_q <= slot_o;
      end
    end
  end
endmodule

// File: rtl/cas_capture.sv
module cas_capture
  import cas_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        mf_mode_i,
  input  logic                        sig_i,
  input  logic [FRAME_W-1:0]          frame_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [BIT_W-1:0]            bit_i,
  output logic [SLOTS-1:0][NIB-1:0]   nib_o,
  output logic [1:0][BITS-1:0]        oct_o
);
  logic cap_en, xfer, nib_phase;

  assign cap_en    = !mf_mode_i || (frame_i == FRAME_W'(FRAMES-1));
  assign xfer      = cap_en && (slot_i == SLOT_W'(SLOTS-1)) && (bit_i == BIT_W'(BITS-1));
  assign nib_phase = bit_i >= BIT_W'(BITS-NIB);

  // Per-slot nibble: capture register plus insertion copy
  for (genvar i = 0; i < SLOTS; i++) begin : g_nib
    if (i == 0 || i == SIG_SLOT) begin : g_octet_slot
      assign nib_o[i] = '0;
    end else begin : g_chan
      logic [NIB-1:0] cap_q, cap_d, ins_q;
      assign cap_d = (cap_en && nib_phase && slot_i == SLOT_W'(i)) ?
                     {cap_q[NIB-2:0], sig_i} : cap_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cap_q <= '0;
          ins_q <= '0;
        end else begin
          cap_q <= cap_d;
          if (xfer) ins_q <= cap_d;
        end
      end
      assign nib_o[i] = ins_q;
    end
  end

  // Full octets for slot 0 (k=0) and the signaling slot (k=1)
  for (genvar k = 0; k < 2; k++) begin : g_oct
    localparam int OSLOT = k * SIG_SLOT;
    logic [BITS-1:0] cap_q, cap_d, ins_q;
    assign cap_d = (cap_en && slot_i == SLOT_W'(OSLOT)) ?
                   {cap_q[BITS-2:0], sig_i} : cap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q <= '0;
        ins_q <= '0;
      end else begin
        cap_q <= cap_d;
        if (xfer) ins_q <= cap_d;
      end
    end
    assign oct_o[k] = ins_q;
  end
endmodule

// File: rtl/cas_insert.sv
module cas_insert
  import cas_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      data_i,
  input  logic                      int_en_i,
  input  logic                      int_bit_i,
  input  logic [FRAME_W-1:0]        frame_i,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic [BIT_W-1:0]          bit_i,
  input  logic [SLOTS-1:0][NIB-1:0] nib_i,
  input  logic [1:0][BITS-1:0]      oct_i,
  output logic                      data_o
);
  logic [SLOT_W-1:0] lo_idx, hi_idx;
  logic [NIB_W-1:0]  nib_pos;
  logic [BIT_W-1:0]  oct_pos;
  logic              sel;

  assign lo_idx  = SLOT_W'(frame_i);
  assign hi_idx  = SLOT_W'(frame_i) + SLOT_W'(SIG_SLOT);
  assign nib_pos = NIB_W'(NIB-1) - NIB_W'(bit_i);
  assign oct_pos = BIT_W'(BITS-1) - bit_i;

  always_comb begin
    sel = data_i;
    if (slot_i == SLOT_W'(SIG_SLOT)) begin
      if (frame_i == '0)                  sel = oct_i[1][oct_pos];
      else if (bit_i < BIT_W'(BITS-NIB))  sel = nib_i[lo_idx][nib_pos];
      else                                sel = nib_i[hi_idx][nib_pos];
    end else if (slot_i == '0 && frame_i[0]) begin
      sel = oct_i[0][oct_pos];
    end
    if (int_en_i) sel = int_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= 1'b0;
    else         data_o <= sel;
  end
endmodule

// File: rtl/cas_inserter.sv
module cas_inserter
  import cas_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic mfsync_i,
  input  logic mf_mode_i,
  input  logic sig_i,
  input  logic data_i,
  input  logic int_en_i,
  input  logic int_bit_i,
  output logic data_o
);
  logic [FRAME_W-1:0]        cur_frame;
  logic [SLOT_W-1:0]         cur_slot;
  logic [BIT_W-1:0]          cur_bit;
  logic [SLOTS-1:0][NIB-1:0] ins_nib;
  logic [1:0][BITS-1:0]      ins_oct;

  cas_timing u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .mfsync_i (mfsync_i),
    .frame_o  (cur_frame),
    .slot_o   (cur_slot),
    .bit_o    (cur_bit)
  );

  cas_capture u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mf_mode_i (mf_mode_i),
    .sig_i     (sig_i),
    .frame_i   (cur_frame),
    .slot_i    (cur_slot),
    .bit_i     (cur_bit),
    .nib_o     (ins_nib),
    .oct_o     (ins_oct)
  );

  cas_insert u_insert (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .int_en_i  (int_en_i),
    .int_bit_i (int_bit_i),
    .frame_i   (cur_frame),
    .slot_i    (cur_slot),
    .bit_i     (cur_bit),
    .nib_i     (ins_nib),
    .oct_i     (ins_oct),
    .data_o    (data_o)
  );
endmodule

// File: rtl/cas_inserter_chk.sv
module cas_inserter_chk
  import cas_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic               mfsync_i,
  input logic               data_i,
  input logic               int_en_i,
  input logic               int_bit_i,
  input logic               data_o,
  input logic [FRAME_W-1:0] frame_i,
  input logic [SLOT_W-1:0]  slot_i,
  input logic [BIT_W-1:0]   bit_i
);
  assert_sync_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |-> (slot_i == '0 && bit_i == '0));

  assert_mf_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mfsync_i |-> frame_i == '0);

  assert_frame_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !sync_i && !mfsync_i) |-> frame_i == $past(frame_i));

  assert_passthrough_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_i && slot_i != '0 && slot_i != SLOT_W'(SIG_SLOT)) |=> data_o == $past(data_i));

  assert_override_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_i |=> data_o == $past(int_bit_i));
endmodule

bind cas_inserter cas_inserter_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .mfsync_i  (mfsync_i),
  .data_i    (data_i),
  .int_en_i  (int_en_i),
  .int_bit_i (int_bit_i),
  .data_o    (data_o),
  .frame_i   (cur_frame),
  .slot_i    (cur_slot),
  .bit_i     (cur_bit)
);

// File: tb/cas_inserter_tb_top.sv
module cas_inserter_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 0, mfsync_i = 0, mf_mode_i = 0, sig_i = 0, data_i = 0;
  logic int_en_i = 0, int_bit_i = 0;
  logic data_o;

  int checks = 0;
  int errors = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  logic [3:0] m_cap_nib [32];
  logic [3:0] m_ins_nib [32];
  logic [7:0] m_cap0, m_cap16, m_ins0, m_ins16;
  string phase_tag = "";

  always #2 clk = ~clk;

  cas_inserter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .mfsync_i(mfsync_i),
    .mf_mode_i(mf_mode_i), .sig_i(sig_i), .data_i(data_i),
    .int_en_i(int_en_i), .int_bit_i(int_bit_i), .data_o(data_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One bit: drive inputs, push expectation, advance reference model
  task automatic drive_bit(input int f, input int ts, input int b, input logic mf);
    item_t it;
    logic s, d, ie, ib;
    s  = 1'($urandom);
    d  = 1'($urandom);
    ie = ($urandom % 16) == 0;
    ib = 1'($urandom);
    @(negedge clk);
    sync_i    = (ts == 0 && b == 0);
    mfsync_i  = (ts == 0 && b == 0 && f == 0);
    mf_mode_i = mf;
    sig_i = s; data_i = d; int_en_i = ie; int_bit_i = ib;
    if (ie) begin
      it.exp = ib; it.tag = "R11";
    end else if (ts == 16) begin
      if (f == 0) begin
        it.exp = m_ins16[7-b]; it.tag = "R7 R5";
      end else begin
        it.exp = (b < 4) ? m_ins_nib[f][3-b] : m_ins_nib[f+16][7-b];
        it.tag = mf ? "R6 R4 R9" : "R6 R4 R10";
      end
    end else if (ts == 0 && f % 2 == 1) begin
      it.exp = m_ins0[7-b]; it.tag = "R8 R5";
    end else begin
      it.exp = d; it.tag = (ts == 0) ? "R8" : "R3";
    end
    it.tag = {phase_tag, it.tag};
    sb_q.push_back(it);
    if (!mf || f == 15) begin
      if (ts == 0)       m_cap0[7-b]  = s;
      else if (ts == 16) m_cap16[7-b] = s;
      else if (b >= 4)   m_cap_nib[ts][7-b] = s;
      if (ts == 31 && b == 7) begin
        m_ins0  = m_cap0;
        m_ins16 = m_cap16;
        for (int i = 0; i < 32; i++) m_ins_nib[i] = m_cap_nib[i];
      end
    end
  endtask

  task automatic run_frame(input int f, input logic mf, input int nbits);
    for (int n = 0; n < nbits; n++) drive_bit(f, n / 8, n % 8, mf);
  endtask

  task automatic run_mframe(input logic mf);
    for (int f = 0; f < 16; f++) run_frame(f, mf, 256);
  endtask

  // Monitor: compare one expected item per clock, after the output register
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (data_o !== it.exp) begin
          errors++;
          $display("FAIL %s: data_o=%b expected %b", it.tag, data_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_cap_nib[i] = '0;
      m_ins_nib[i] = '0;
    end
    m_cap0 = '0; m_cap16 = '0; m_ins0 = '0; m_ins16 = '0;
    data_i = 1; int_en_i = 1; int_bit_i = 1; sig_i = 1;
    // R1: output held low in reset whatever the inputs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (data_o !== 1'b0) begin
        errors++;
        $display("FAIL R1: data_o=%b expected 0", data_o);
      end
    end
    @(negedge clk);
    data_i = 0; int_en_i = 0; int_bit_i = 0; sig_i = 0;
    rst_ni = 1'b1;

    // R9: multiframe capture, cleared buffers in first multiframe
    for (int m = 0; m < 3; m++) run_mframe(1'b1);
    // R10: capture every frame
    for (int m = 0; m < 2; m++) run_mframe(1'b0);
    // R2: cut a frame short, restart multiframe mid-frame
    run_frame(0, 1'b0, 300 % 256);
    run_frame(1, 1'b0, 77);
    phase_tag = "R2 ";
    run_mframe(1'b0);
    phase_tag = "";
    run_mframe(1'b1);
    run_mframe(1'b1);

    wait (sb_q.size() == 0);
    @(negedge clk);
    summary();
  end
endmodule